// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital control path in front of a two-channel 12-bit digital-to-analog converter. A host shifts a 16-bit command word in over a three-wire serial link: a serial clock, an active-low frame select and a data line. The bits are captured on serial clock rising edges while the frame select is low. When the frame select returns high, the captured word is decoded. The command can load a per-channel holding ("input") register, move holding values into the output ("DAC") registers, write both stages at once, or shut a channel down with a chosen output termination.

All serial and strobe inputs are treated as asynchronous to the block clock. They pass through a configurable synchronizer, and edges are detected in the clock domain. A separate active-low load strobe copies both holding registers into the DAC registers for as long as it is held low, with no frame needed. The outputs are two DAC codes, a shutdown flag and a termination select per channel, and a bias-enable flag for the shared analog bias.

Top module: `dacfe_top`

## Requirements
- R1: A frame is the sequence of serial clock rising edges seen while `cs_n` is low. Bits arrive MSB first in this layout: word[15:13] is the opcode, word[12:1] is the 12-bit data with D11 at word[12], and word[0] is a trailing bit that takes no part in decoding. The command takes effect on the rising edge of `cs_n`, and the outputs reflect it within 6 clock cycles of that edge.
- R2: A frame whose `cs_n` rises after any count of serial clock edges other than exactly 16 is dropped and changes no output.
- R3: Opcode 3'b001 loads the data into holding register A, and opcode 3'b101 loads it into holding register B. Neither changes a DAC register.
- R4: Opcode 3'b010 loads holding A, then updates both DAC registers: A takes the new data and B takes holding B. Opcode 3'b110 does the same with the channels swapped.
- R5: Opcode 3'b011 writes the data into both holding registers and both DAC registers. Opcode 3'b100 copies each holding register into its DAC register.
- R6: Opcode 3'b111 shuts down both channels. `shdn_load[0]` takes D11 and `shdn_load[1]` takes D10. On `shdn_load`, 0 selects the low-impedance (1 kΩ) termination and 1 selects the high-impedance (200 kΩ) termination. `bias_en` is unchanged.
- R7: With opcode 3'b000, D11..D9 selects a sub-command. 3'b001 updates DAC A from holding A. 3'b101 updates DAC B from holding B. 3'b110 shuts down A with load bit D8. 3'b111 shuts down B with load bit D8. Any sub-code not listed here, or under R8, leaves every output unchanged.
- R8: Opcode 3'b000 with sub-code 3'b011 is full power-down. It clears `bias_en` and shuts down both channels, with A's load bit from D8 and B's from D7.
- R9: Any command that writes a channel's DAC register clears that channel's shutdown flag and sets `bias_en`. The other channel's shutdown flag is unchanged.
- R10: While `ldac_n` is low, each DAC register takes its holding register value. `chan_shdn`, `shdn_load` and `bias_en` are not affected.
- R11: Reset clears both holding and DAC registers to zero, clears both shutdown flags and load bits, and sets `bias_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| din | input | 1 | Serial data, asynchronous |
| ldac_n | input | 1 | Active-low load strobe, asynchronous |
| dac_code_a | output | 12 | DAC register of channel A |
| dac_code_b | output | 12 | DAC register of channel B |
| chan_shdn | output | 2 | Shutdown flag per channel, bit 0 = A |
| shdn_load | output | 2 | Termination select per channel, 1 = high impedance |
| bias_en | output | 1 | Shared bias enable |

## Verification
A holding register that is corrupted stays hidden at the ports until a later DAC update or load strobe copies it out. For that reason, every holding-register load in the sequence is followed by a strobe or an update command. A wrong shutdown or bias state shows up within the six-cycle latency of the command that set it. The sequence walks the bias through power-down and wake, so a missed wake or a wrong-channel wake is visible on `chan_shdn` and `bias_en` at the next comparison. A frame-count error appears as code changes after frames that should have been dropped.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  localparam int DATA_W = 12;
  localparam int OP_W   = 3;
  localparam int SUB_W  = 3;
  localparam int NCH    = 2;
  localparam int WORD_W = OP_W + DATA_W + 1;
  localparam int CMD_W  = OP_W + DATA_W;

  typedef struct packed {
    logic [NCH-1:0]    ld_in;
    logic [NCH-1:0]    upd;
    logic [NCH-1:0]    sd_set;
    logic [NCH-1:0]    sd_bit;
    logic              bias_off;
    logic [DATA_W-1:0] data;
  } ctl_t;
endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
module dacfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
`timescale 1ns/1ps
module dacfe_shifter
  import dacfe_pkg::*;
#(
  parameter int NBITS = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,        // synchronized frame select, active high
  input  logic             bit_in,
  input  logic             shift_en,   // serial clock rising edge
  input  logic             frame_end,  // frame select released
  output logic             word_valid,
  output logic [NBITS-2:0] word
);
  localparam int CNT_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);

  logic [NBITS-1:0] sr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= frame_end && (cnt == CNT_FULL);
      if (!sel) begin
        cnt <= '0;
      end else if (shift_en) begin
        sr <= {sr[NBITS-2:0], bit_in};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  assign word = sr[NBITS-1:1];
endmodule

// File: rtl/dacfe_decode.sv
`timescale 1ns/1ps
module dacfe_decode
  import dacfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd,
  output ctl_t             ctl
);
  localparam int D_TOP = DATA_W - 1;

  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] d;
  logic [SUB_W-1:0]  sub;
  ctl_t              nxt;

  assign op  = cmd[CMD_W-1 -: OP_W];
  assign d   = cmd[DATA_W-1:0];
  assign sub = d[D_TOP -: SUB_W];

  always_comb begin
    nxt      = '0;
    nxt.data = d;
    unique case (op)
      3'b001: nxt.ld_in = 2'b01;
      3'b010: begin nxt.ld_in = 2'b01; nxt.upd = 2'b11; end
      3'b011: begin nxt.ld_in = 2'b11; nxt.upd = 2'b11; end
      3'b100: nxt.upd = 2'b11;
      3'b101: nxt.ld_in = 2'b10;
      3'b110: begin nxt.ld_in = 2'b10; nxt.upd = 2'b11; end
      3'b111: begin
        nxt.sd_set = 2'b11;
        nxt.sd_bit = {d[D_TOP-1], d[D_TOP]};
      end
      default: begin
        case (sub)
          3'b001: nxt.upd = 2'b01;
          3'b101: nxt.upd = 2'b10;
          3'b011: begin
            nxt.sd_set   = 2'b11;
            nxt.sd_bit   = {d[D_TOP-4], d[D_TOP-3]};
            nxt.bias_off = 1'b1;
          end
          3'b110: begin nxt.sd_set = 2'b01; nxt.sd_bit = {1'b0, d[D_TOP-3]}; end
          3'b111: begin nxt.sd_set = 2'b10; nxt.sd_bit = {d[D_TOP-3], 1'b0}; end
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            ctl <= '0;
    else if (cmd_valid) ctl <= nxt;
    else                ctl <= '0;
  end
endmodule

// File: rtl/dacfe_channel.sv
`timescale 1ns/1ps
module dacfe_channel
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_in,
  input  logic              upd,
  input  logic              sd_set,
  input  logic              sd_bit,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code,
  output logic              shdn,
  output logic              load_sel
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      code     <= '0;
      shdn     <= 1'b0;
      load_sel <= 1'b0;
    end else begin
      if (ld_in) hold_q <= data;
      if (upd || strobe) code <= ld_in ? data : hold_q;
      if (upd) begin
        shdn <= 1'b0;
      end else if (sd_set) begin
        shdn     <= 1'b1;
        load_sel <= sd_bit;
      end
    end
  end
endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              ldac_n,
  output logic [DATA_W-1:0] dac_code_a,
  output logic [DATA_W-1:0] dac_code_b,
  output logic [NCH-1:0]    chan_shdn,
  output logic [NCH-1:0]    shdn_load,
  output logic              bias_en
);
  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1100;  // {ldac_n, cs_n, sclk, din}

  logic [PIN_N-1:0]  pins_s;
  logic              sclk_d, cs_d;
  logic              sclk_rise, cs_rise;
  logic              word_valid;
  logic [CMD_W-1:0]  word;
  ctl_t              ctl;
  logic [DATA_W-1:0] codes [NCH];

  dacfe_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d({ldac_n, cs_n, sclk, din}), .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= pins_s[1];
      cs_d   <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[1] & ~sclk_d;
  assign cs_rise   = pins_s[2] & ~cs_d;

  dacfe_shifter #(.NBITS(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sel(~pins_s[2]), .bit_in(pins_s[0]),
    .shift_en(sclk_rise), .frame_end(cs_rise),
    .word_valid(word_valid), .word(word)
  );

  dacfe_decode u_dec (
    .clk(clk), .rst(rst), .cmd_valid(word_valid), .cmd(word), .ctl(ctl)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dacfe_channel u_ch (
      .clk(clk), .rst(rst),
      .ld_in(ctl.ld_in[ch]), .upd(ctl.upd[ch]),
      .sd_set(ctl.sd_set[ch]), .sd_bit(ctl.sd_bit[ch]),
      .strobe(~pins_s[3]), .data(ctl.data),
      .code(codes[ch]), .shdn(chan_shdn[ch]), .load_sel(shdn_load[ch])
    );
  end

  assign dac_code_a = codes[0];
  assign dac_code_b = codes[1];

  always_ff @(posedge clk) begin
    if (rst)               bias_en <= 1'b1;
    else if (|ctl.upd)     bias_en <= 1'b1;
    else if (ctl.bias_off) bias_en <= 1'b0;
  end
endmodule

// File: rtl/dacfe_chk.sv
`timescale 1ns/1ps
module dacfe_chk
  import dacfe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ldac_n,
  input logic [DATA_W-1:0] dac_code_a,
  input logic [DATA_W-1:0] dac_code_b,
  input logic [NCH-1:0]    chan_shdn,
  input logic [NCH-1:0]    shdn_load,
  input logic              bias_en
);
  localparam int QUIET = 8;
  logic [3:0] idle_cnt, cs_cnt;

  always_ff @(posedge clk) begin
    if (rst || !cs_n || !ldac_n) idle_cnt <= '0;
    else if (idle_cnt != 4'hF)   idle_cnt <= idle_cnt + 1'b1;
    if (rst || !cs_n)            cs_cnt <= '0;
    else if (cs_cnt != 4'hF)     cs_cnt <= cs_cnt + 1'b1;
  end

  // R11: reset state
  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (dac_code_a == '0 && dac_code_b == '0 && chan_shdn == '0 &&
             shdn_load == '0 && bias_en));

  // R1: nothing moves once the serial and strobe lines have been idle
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= QUIET) |-> ($stable(dac_code_a) && $stable(dac_code_b) &&
                             $stable(chan_shdn) && $stable(bias_en)));

  // R10: the load strobe alone never touches shutdown or bias state
  p_strobe_no_shdn_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_cnt >= QUIET) |-> ($stable(chan_shdn) && $stable(shdn_load) && $stable(bias_en)));

  // R8: bias only drops together with both channels shut down
  p_bias_off_both_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(bias_en) |-> (chan_shdn == 2'b11));

  // R9: a wake brings the bias back in the same cycle
  p_wake_bias_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(chan_shdn[0]) || $fell(chan_shdn[1])) |-> bias_en);

  // R9: the bias returns only when some channel is awake
  p_bias_on_awake_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bias_en) |-> (chan_shdn != 2'b11));
endmodule

bind dacfe_top dacfe_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ldac_n(ldac_n),
  .dac_code_a(dac_code_a), .dac_code_b(dac_code_b),
  .chan_shdn(chan_shdn), .shdn_load(shdn_load), .bias_en(bias_en)
);

// File: tb/dacfe_top_tb.sv
`timescale 1ns/1ps
module dacfe_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ldac_n = 1'b1;
  logic [11:0] dac_code_a, dac_code_b;
  logic [1:0]  chan_shdn, shdn_load;
  logic        bias_en;

  always #2 clk = ~clk;

  dacfe_top u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .ldac_n(ldac_n),
    .dac_code_a(dac_code_a), .dac_code_b(dac_code_b),
    .chan_shdn(chan_shdn), .shdn_load(shdn_load), .bias_en(bias_en)
  );

  typedef struct {
    logic [11:0] a, b;
    logic [1:0]  sd, ld;
    logic        bias;
    string       tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  logic [11:0] m_in [2];
  logic [11:0] m_dac [2];
  logic [1:0]  m_sd, m_ld;
  logic        m_bias;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(string tag);
    exp_t e;
    e.a = m_dac[0]; e.b = m_dac[1]; e.sd = m_sd; e.ld = m_ld; e.bias = m_bias; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic void wake(int ch, logic [11:0] v);
    m_dac[ch] = v;
    m_sd[ch]  = 1'b0;
    m_bias    = 1'b1;
  endfunction

  function automatic void model(logic [15:0] w);
    logic [2:0]  op;
    logic [11:0] d;
    op = w[15:13];
    d  = w[12:1];
    case (op)
      3'b001: m_in[0] = d;
      3'b101: m_in[1] = d;
      3'b010: begin m_in[0] = d; wake(0, d); wake(1, m_in[1]); end
      3'b110: begin m_in[1] = d; wake(1, d); wake(0, m_in[0]); end
      3'b011: begin m_in[0] = d; m_in[1] = d; wake(0, d); wake(1, d); end
      3'b100: begin wake(0, m_in[0]); wake(1, m_in[1]); end
      3'b111: begin m_sd = 2'b11; m_ld = {d[10], d[11]}; end
      default: case (d[11:9])
        3'b001: wake(0, m_in[0]);
        3'b101: wake(1, m_in[1]);
        3'b011: begin m_sd = 2'b11; m_ld = {d[7], d[8]}; m_bias = 1'b0; end
        3'b110: begin m_sd[0] = 1'b1; m_ld[0] = d[8]; end
        3'b111: begin m_sd[1] = 1'b1; m_ld[1] = d[8]; end
        default: ;
      endcase
    endcase
  endfunction

  task automatic send(logic [2:0] op, logic [11:0] d, int nclk, string tag);
    logic [15:0] w;
    w = {op, d, 1'b0};
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nclk; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    if (nclk == 16) model(w);
    push(tag);
    tick(20);
  endtask

  task automatic strobe(string tag);
    ldac_n = 1'b0;
    tick(3);
    ldac_n = 1'b1;
    m_dac[0] = m_in[0];
    m_dac[1] = m_in[1];
    push(tag);
    tick(20);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() > 0);
      repeat (12) @(negedge clk);
      e = q.pop_front();
      vectors++;
      if (dac_code_a !== e.a || dac_code_b !== e.b || chan_shdn !== e.sd ||
          shdn_load !== e.ld || bias_en !== e.bias) begin
        miscompares++;
        $display("FAIL %s: got a=%h b=%h sd=%b ld=%b bias=%b, expected a=%h b=%h sd=%b ld=%b bias=%b",
                 e.tag, dac_code_a, dac_code_b, chan_shdn, shdn_load, bias_en,
                 e.a, e.b, e.sd, e.ld, e.bias);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected sequence end");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    m_sd = '0; m_ld = '0; m_bias = 1'b1;
    tick(6);
    rst = 1'b0;
    push("R11 reset state");
    tick(20);
    send(3'b001, 12'h5A3, 16, "R3 R1 load holding A only");
    strobe("R10 strobe moves holding A");
    send(3'b101, 12'h0F0, 16, "R3 load holding B only");
    send(3'b010, 12'h123, 16, "R4 load A, update both");
    send(3'b110, 12'hABC, 16, "R4 load B, update both");
    send(3'b011, 12'h7FF, 16, "R5 write both stages");
    send(3'b001, 12'h001, 16, "R3 load holding A");
    send(3'b101, 12'hFFE, 16, "R3 load holding B");
    send(3'b100, 12'h000, 16, "R5 copy holding to DAC");
    send(3'b111, 12'h800, 16, "R6 shut both, A hi-Z B low-Z");
    send(3'b000, 12'h200, 16, "R7 R9 wake A from holding");
    send(3'b000, 12'h680, 16, "R8 full power-down A=0 B=1");
    send(3'b001, 12'h3C3, 16, "R3 holding A while shut");
    strobe("R10 strobe keeps shutdown");
    send(3'b000, 12'hA00, 16, "R9 wake B re-enables bias");
    send(3'b000, 12'hD00, 16, "R7 shut A load 1");
    send(3'b000, 12'hE00, 16, "R7 shut B load 0");
    send(3'b000, 12'h400, 16, "R7 unlisted sub-code no-op");
    send(3'b011, 12'hEEE, 15, "R2 short frame dropped");
    send(3'b011, 12'hEEE, 17, "R2 long frame dropped");
    send(3'b110, 12'h6D9, 16, "R4 R9 wake both");
    wait (q.size() == 0);
    tick(16);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule